// File: doc/BRIEF.md
# Differential Escalation Pair Receiver

This block sits at the receiving end of a two-wire escalation link. It decodes the incoming pair and decides whether the sender issued a one-cycle liveness probe (a ping) or a sustained escalation. It answers on a second two-wire response pair that the sender watches. A ping is acknowledged with a short, fixed toggle pattern. A held escalation is answered by continuous toggling for as long as it lasts, and a local escalation flag is raised for the logic that must act on it.

Any pair value that is not one of the two legal encodings is an integrity fault. The receiver reports it by driving both response wires to the same value and toggling them together, which the sender reads as a broken link. Inputs are assumed to be already synchronous to the clock. The response outputs come straight from flops.

Top module: `esc_pair_receiver`

## Requirements
- R1: While rst_n is sampled low at a rising edge, the next cycle shows resp_p=0, resp_n=1 and esc_out=0. The reset is synchronous and active low.
- R2: Only esc_p=1 with esc_n=0 is sampled as a request. The pair esc_p=0, esc_n=1 is the idle input, and with no response pending it leaves resp_p=0, resp_n=1.
- R3: After any edge that samples a legal input (esc_p differs from esc_n), resp_n is the inverse of resp_p in the following cycle.
- R4: A request sampled on one edge only, starting from idle, gives resp_p = 1, 0, 1, 0 in the four cycles after that edge, and resp_p=0 (idle) after that.
- R5: If a request is sampled on two or more consecutive edges, resp_p is 1 after the first of those edges and then inverts after every further edge that samples the request.
- R6: On the first edge that samples idle after a request, the response value already on the outputs stays visible for that cycle. The outputs return to idle in the cycle after that edge.
- R7: A request sampled during the second, third or fourth cycle of a ping answer abandons the ping pattern. resp_p is 1 in the next cycle, and the escalation toggling of R5 follows while the request is held.
- R8: When esc_p equals esc_n at an edge, resp_p equals resp_n in the next cycle. Both are 1 on the first such edge and both invert on each further consecutive one. A legal input leaves this fault signalling at the next edge.
- R9: esc_out is 1 in the cycle after an edge that samples a request when the previous edge also sampled a request. Otherwise it is 0, so a single-cycle ping never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| esc_p | input | 1 | Positive wire of the incoming escalation pair |
| esc_n | input | 1 | Negative wire of the incoming escalation pair |
| resp_p | output | 1 | Positive wire of the response pair |
| resp_n | output | 1 | Negative wire of the response pair |
| esc_out | output | 1 | Local escalation indication |

## Verification
Two functions can overlap. A ping answer may still be toggling when a new request arrives, and an escalation may be in progress when the pair loses integrity. The bench provokes the first by requesting in each of the four ping answer cycles, including the first one, where a second request makes it a held escalation. It provokes the second by forcing equal wires in the middle of a held escalation and again in the middle of a ping. A behavioural model built on a queue of pending response values and a record of the last sampled request predicts the next pair on every clock. Each cycle is judged on resp_p, on resp_n (as the inverse of resp_p, or as its copy during a fault) and on esc_out.

// File: rtl/esc_pair_pkg.sv
`timescale 1ns/1ps
// Shared types for the escalation pair receiver.
package esc_pair_pkg;

    // Response sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PING  = 2'd1,
        ST_ESC   = 2'd2,
        ST_FAULT = 2'd3
    } rx_state_e;

endpackage : esc_pair_pkg

// File: rtl/esc_pair_decode.sv
`timescale 1ns/1ps
// Pair decoder.
// Classifies the incoming two-wire pair into a request and an integrity fault.
// Assumes the inputs are already synchronous to the clock; purely combinational.
module esc_pair_decode (
    input  logic wire_p,
    input  logic wire_n,
    output logic req_o,
    output logic fault_o
);

    // Request only on the one legal asserted encoding; equal wires are a fault.
    always_comb begin
        req_o   = wire_p & ~wire_n;
        fault_o = ~(wire_p ^ wire_n);
    end

endmodule : esc_pair_decode

// File: rtl/esc_pair_hold_detect.sv
`timescale 1ns/1ps
// Held-request detector.
// Raises the escalation flag once a request has been sampled on two
// consecutive edges, so that a one-cycle ping never reaches it.
// Assumes req_i comes from the pair decoder in the same clock domain.
module esc_pair_hold_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic esc_o
);

    logic req_q;

    // Remember the last sampled request and flag two in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            esc_o <= 1'b0;
        end else begin
            req_q <= req_i;
            esc_o <= req_i & req_q;
        end
    end

    // R9: an edge without a request clears the flag
    p_flag_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !esc_o);

    // R9: two consecutive requests always raise the flag
    p_flag_on_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && req_q) |=> esc_o);

endmodule : esc_pair_hold_detect

// File: rtl/esc_pair_resp_fsm.sv
`timescale 1ns/1ps
// Response sequencer.
// Produces the positive response wire and a fault indication from the decoded
// request and fault strobes: a fixed toggle run for a ping, continuous toggling
// for a held escalation, common-mode toggling for an integrity fault.
// Assumes PingCycles >= 1 (an even value ends the ping run low before idle).
module esc_pair_resp_fsm
    import esc_pair_pkg::*;
#(
    parameter int PingCycles = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fault_i,
    output logic resp_o,
    output logic fault_o
);

    localparam int CntW = (PingCycles > 1) ? $clog2(PingCycles) : 1;
    localparam logic [CntW-1:0] CntTop = CntW'(PingCycles - 1);

    rx_state_e       state_q, state_d;
    logic [CntW-1:0] cnt_q, cnt_d;
    logic            resp_q, resp_d;

    // Next-state and next-response selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        resp_d  = resp_q;
        if (fault_i) begin
            state_d = ST_FAULT;
            cnt_d   = '0;
            resp_d  = (state_q == ST_FAULT) ? ~resp_q : 1'b1;
        end else if (req_i) begin
            unique case (state_q)
                ST_PING: begin
                    // second consecutive request toggles; a late one restarts high
                    state_d = ST_ESC;
                    cnt_d   = '0;
                    resp_d  = (cnt_q == CntTop) ? ~resp_q : 1'b1;
                end
                ST_ESC: begin
                    resp_d = ~resp_q;
                end
                default: begin
                    state_d = ST_PING;
                    cnt_d   = CntTop;
                    resp_d  = 1'b1;
                end
            endcase
        end else begin
            if (state_q == ST_PING && cnt_q != '0) begin
                cnt_d  = cnt_q - 1'b1;
                resp_d = ~resp_q;
            end else begin
                state_d = ST_IDLE;
                cnt_d   = '0;
                resp_d  = 1'b0;
            end
        end
    end

    // State, counter and response registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            resp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            resp_q  <= resp_d;
        end
    end

    // Outputs come straight from flops.
    always_comb begin
        resp_o  = resp_q;
        fault_o = (state_q == ST_FAULT);
    end

    // R4: a ping run keeps alternating while cycles remain
    p_ping_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PING && !req_i && !fault_i && cnt_q != '0) |=> resp_q != $past(resp_q));

    // R7: a request late in the ping run restarts the answer high
    p_ping_interrupt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PING && req_i && !fault_i && cnt_q != CntTop) |=> (resp_q && state_q == ST_ESC));

    // R5: a held escalation keeps toggling
    p_esc_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ESC && req_i && !fault_i) |=> resp_q != $past(resp_q));

endmodule : esc_pair_resp_fsm

// File: rtl/esc_pair_receiver.sv
`timescale 1ns/1ps
// Escalation pair receiver (top).
// Decodes the escalation pair, sequences the response pair and raises the
// local escalation flag. The response pair is complementary except while an
// integrity fault is being signalled, when both wires carry the same value.
// Assumes esc_p/esc_n are synchronous to clk.
module esc_pair_receiver #(
    parameter int PingCycles = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic esc_p,
    input  logic esc_n,
    output logic resp_p,
    output logic resp_n,
    output logic esc_out
);

    logic req;
    logic fault;
    logic resp_raw;
    logic fault_state;

    esc_pair_decode u_decode (
        .wire_p  (esc_p),
        .wire_n  (esc_n),
        .req_o   (req),
        .fault_o (fault)
    );

    esc_pair_resp_fsm #(
        .PingCycles (PingCycles)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .fault_i (fault),
        .resp_o  (resp_raw),
        .fault_o (fault_state)
    );

    esc_pair_hold_detect u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .esc_o (esc_out)
    );

    // Encode the response pair: complementary normally, common-mode on fault.
    always_comb begin
        resp_p = resp_raw;
        resp_n = fault_state ? resp_raw : ~resp_raw;
    end

    // R1: reset forces the idle response and clears the flag
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!resp_p && resp_n && !esc_out));

    // R3: a legal input pair yields a complementary response
    p_complement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_p != esc_n) |=> (resp_p != resp_n));

    // R8: equal input wires yield equal response wires
    p_fault_common_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_p == esc_n) |=> (resp_p == resp_n));

    // R6: an escalation that drops returns the pair to idle one cycle later
    p_drop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_out && !esc_p && esc_n) |=> (!resp_p && resp_n && !esc_out));

endmodule : esc_pair_receiver

// File: tb/esc_pair_receiver_bench.sv
`timescale 1ns/1ps
module esc_pair_receiver_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic esc_p;
    logic esc_n;
    logic resp_p;
    logic resp_n;
    logic esc_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    esc_pair_receiver u_esc_pair_receiver (
        .clk     (clk),
        .rst_n   (rst_n),
        .esc_p   (esc_p),
        .esc_n   (esc_n),
        .resp_p  (resp_p),
        .resp_n  (resp_n),
        .esc_out (esc_out)
    );

    // ---------------- behavioural reference ----------------
    bit    m_p    = 1'b0;
    bit    m_n    = 1'b1;
    bit    m_esc  = 1'b0;
    bit    m_prev = 1'b0;   // request sampled on the previous edge
    bit    m_hold = 1'b0;   // escalation answer mode
    bit    m_busy = 1'b0;   // a ping answer value is on the outputs
    bit    m_flt  = 1'b0;   // fault signalling active
    bit    pend[$];         // remaining ping answer values
    string m_tag  = "R1";

    always @(posedge clk) begin
        bit r;
        bit ie;
        if (!rst_n) begin
            m_p = 0; m_n = 1; m_esc = 0; m_prev = 0;
            m_hold = 0; m_busy = 0; m_flt = 0; pend.delete();
            m_tag = "R1";
        end else begin
            r  = esc_p && !esc_n;
            ie = (esc_p == esc_n);
            m_esc = r && m_prev;
            if (ie) begin
                m_p = m_flt ? !m_p : 1'b1;
                m_n = m_p;
                m_flt = 1; m_hold = 0; m_busy = 0; pend.delete();
                m_tag = "R8";
            end else if (r) begin
                m_flt = 0;
                if (m_hold || m_prev) begin
                    m_p = !m_p; m_hold = 1; m_busy = 0; pend.delete();
                    m_tag = "R5";
                end else if (m_busy) begin
                    m_p = 1; m_hold = 1; m_busy = 0; pend.delete();
                    m_tag = "R7";
                end else begin
                    m_p = 1; m_busy = 1;
                    pend.delete(); pend.push_back(0); pend.push_back(1); pend.push_back(0);
                    m_tag = "R4";
                end
                m_n = !m_p;
            end else begin
                m_tag = m_hold ? "R6" : (pend.size() > 0 ? "R4" : "R2");
                m_flt = 0; m_hold = 0;
                if (pend.size() > 0) begin
                    m_p = pend.pop_front(); m_busy = 1;
                end else begin
                    m_p = 0; m_busy = 0;
                end
                m_n = !m_p;
            end
            m_prev = r;
        end
    end

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare at the falling edge, then drive the next input pair.
    task automatic cyc(input bit p, input bit n);
        @(negedge clk);
        check_bit(m_tag, "resp_p", resp_p, m_p);
        check_bit(m_flt ? "R8" : "R3", "resp_n", resp_n, m_n);
        check_bit("R9", "esc_out", esc_out, m_esc);
        esc_p = p;
        esc_n = n;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(0, 1);
    endtask

    task automatic hold(input int k);
        for (int i = 0; i < k; i++) cyc(1, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        esc_p = 1'b0;
        esc_n = 1'b1;
        idle(3);                              // R1 reset state
        @(negedge clk); rst_n = 1'b1;
        idle(4);                              // R2 idle stays idle
        hold(1); idle(7);                     // R4 single ping, R9 no flag
        hold(1); idle(1); hold(1); idle(6);   // R7 request in second answer cycle
        hold(1); idle(2); hold(1); idle(6);   // R7 third cycle
        hold(1); idle(3); hold(1); idle(6);   // R7 fourth cycle
        hold(2); idle(5);                     // R5 request in first cycle = held
        hold(6); idle(4);                     // R5 held toggling, R6 drop, R9 flag
        hold(1); idle(2); hold(4); idle(4);   // R7 then held escalation
        cyc(1, 1); cyc(1, 1); cyc(0, 0); idle(4);   // R8 fault toggling
        hold(3); cyc(1, 1); cyc(0, 0); hold(2); idle(4); // R8 fault during escalation
        hold(1); idle(1); cyc(0, 0); hold(1); idle(6);   // R8 fault during ping
        cyc(1, 1); hold(1); idle(6);          // R8 exit into a fresh ping
        hold(3); @(negedge clk); rst_n = 1'b0; idle(2);  // R1 reset mid escalation
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        for (int i = 0; i < 400; i++) begin
            int v;
            v = $urandom_range(0, 9);
            if (v < 4)      cyc(0, 1);
            else if (v < 9) cyc(1, 0);
            else            cyc(v[0], v[0]);
        end
        idle(6);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule : esc_pair_receiver_bench